// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating and Driver Enable

This block turns bytes from a ready/valid input into asynchronous serial frames on a single output line. An external bit-rate tick sets the pace, and each bit lasts exactly one tick period. The number of data bits, the parity mode and the number of stop bits are set per character. The block takes a snapshot of these settings when it accepts a character, so a later change cannot affect a frame that is already on the line.

Before it accepts a character, the block checks the clear-to-send input. While that input is low, the block refuses new data and the line stays idle. A clear-to-send drop in the middle of a character does not cut that character short; it only delays the next one.

For half-duplex transceivers, the block drives an enable output. This output is high from the first cycle of the start bit until the last stop bit has fully ended. When it drops, the block pulses a one-clock completion strobe in the same cycle.

Top module: `uart_tx_flow`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `tx` is high, `drv_en` is low and `tx_done` is low.
- R2: A frame is sent as a low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits, which are high.
- R3: `cfg_data_bits` selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. Bits of `in_data` at or above the selected count are not sent.
- R4: With `cfg_parity_en` high, a parity bit follows the data. With `cfg_parity_odd` low, the count of ones across the data bits and the parity bit is even; with it high, that count is odd.
- R5: `cfg_two_stop` selects 2 stop bits when high and 1 when low. A frame therefore spans 1 + data + parity + stop bit periods (10 for 8 bits, no parity, 1 stop; 11 with parity; 12 with 2 stops).
- R6: `in_ready` is high only when no frame is in progress and `cts` is high. While `cts` is low, no frame starts and `tx` stays high.
- R7: Dropping `cts` during a frame does not shorten or alter that frame.
- R8: Data and configuration are captured in the cycle a character is accepted (`in_valid` and `in_ready` both high). Changes to them while the frame is sent have no effect on it.
- R9: The start bit begins in the cycle after acceptance. Each later bit begins in the cycle after a `bit_tick` pulse; a tick in the acceptance cycle is not counted. The line changes only on those boundaries. `drv_en` is high for every cycle of the frame and falls in the cycle after the tick that ends the last stop bit.
- R10: `tx_done` is high for exactly one clock, in the cycle `drv_en` falls. `in_ready` stays low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| cfg_data_bits | input | 4 | Data bit count, 5 to 9 (clamped) |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_parity_odd | input | 1 | Odd parity when high, even when low |
| cfg_two_stop | input | 1 | Two stop bits when high |
| cts | input | 1 | Clear to send, active high |
| in_valid | input | 1 | Character available |
| in_data | input | 9 | Character, bit 0 sent first |
| in_ready | output | 1 | Character accepted when high with in_valid |
| tx | output | 1 | Serial line, idle high |
| drv_en | output | 1 | Transceiver driver enable |
| tx_done | output | 1 | One-cycle pulse at frame completion |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of mistake.
- **Frame lengths.** It uses the shortest frame (5 bits, no parity, 1 stop) and the longest (9 bits, parity, 2 stops), plus out-of-range bit counts that must clamp. A design that counted length wrongly would end `drv_en` early or late, or drop a stop bit.
- **Tick spacing.** It sends frames with a tick every clock. A design that counted the acceptance-cycle tick would shorten the start bit.
- **Flow control and configuration.** It holds `cts` low with data waiting, and toggles `cts`, data and configuration randomly during frames. A design that re-read its settings, or that checked `cts` mid-character, would send a corrupted or truncated frame.
- **Parity and stuffing.** Random data in both parity modes catches an inverted parity sense. Set high bits above the data count catch data leaking into the parity or stop positions.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

    localparam int MIN_BITS   = 5;
    localparam int MAX_BITS   = 9;
    localparam int MAX_STOP   = 2;
    localparam int NBITS_W    = 4;
    localparam int FRAME_MAX  = 1 + MAX_BITS + 1 + MAX_STOP;
    localparam int LEN_W      = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1
    } seq_state_t;

    typedef struct packed {
        logic [NBITS_W-1:0] data_bits;
        logic               par_en;
        logic               par_odd;
        logic               two_stop;
    } line_cfg_t;

    function automatic logic [NBITS_W-1:0] clamp_bits(input logic [NBITS_W-1:0] n);
        if (int'(n) < MIN_BITS)      return NBITS_W'(MIN_BITS);
        else if (int'(n) > MAX_BITS) return NBITS_W'(MAX_BITS);
        else                         return n;
    endfunction

    function automatic logic data_parity(input logic [MAX_BITS-1:0] d,
                                         input logic [NBITS_W-1:0] n,
                                         input logic odd);
        logic p;
        p = odd;
        for (int i = 0; i < MAX_BITS; i++) begin
            if (i < int'(n)) p = p ^ d[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/uart_txf_framer.sv
module uart_txf_framer
    import uart_txf_pkg::*;
(
    input  line_cfg_t            cfg,
    input  logic [MAX_BITS-1:0]  data,
    output logic [FRAME_MAX-1:0] frame,
    output logic [LEN_W-1:0]     frame_len
);
    logic [NBITS_W-1:0] nbits;
    logic               par_bit;

    always_comb begin
        nbits   = clamp_bits(cfg.data_bits);
        par_bit = data_parity(data, nbits, cfg.par_odd);
        frame   = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < MAX_BITS; i++) begin
            if (i < int'(nbits)) frame[1+i] = data[i];
        end
        for (int i = MIN_BITS; i <= MAX_BITS; i++) begin
            if (cfg.par_en && i == int'(nbits)) frame[1+i] = par_bit;
        end
        frame_len = LEN_W'(1 + int'(nbits) + (cfg.par_en ? 1 : 0) + (cfg.two_stop ? 2 : 1));
    end
endmodule

// File: rtl/uart_txf_shifter.sv
module uart_txf_shifter #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         serial
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)        sh_q <= '1;
        else if (load)  sh_q <= load_val;
        else if (shift) sh_q <= {1'b1, sh_q[W-1:1]};
    end

    assign serial = sh_q[0];
endmodule

// File: rtl/uart_txf_seq.sv
module uart_txf_seq
    import uart_txf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             in_valid,
    input  logic             cts,
    input  logic [LEN_W-1:0] frame_len,
    output logic             accept,
    output logic             shift_en,
    output logic             busy,
    output logic             done_pulse,
    output logic             in_ready
);
    seq_state_t       state_q;
    logic [LEN_W-1:0] left_q;
    logic             done_q;

    assign in_ready   = (state_q == ST_IDLE) && cts;
    assign accept     = in_valid && in_ready;
    assign shift_en   = (state_q == ST_SEND) && bit_tick;
    assign busy       = (state_q == ST_SEND);
    assign done_pulse = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_SEND;
                        left_q  <= frame_len;
                    end
                end
                ST_SEND: begin
                    if (bit_tick) begin
                        if (left_q == LEN_W'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                        left_q <= left_q - LEN_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
    import uart_txf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_tick,
    input  logic [NBITS_W-1:0]  cfg_data_bits,
    input  logic                cfg_parity_en,
    input  logic                cfg_parity_odd,
    input  logic                cfg_two_stop,
    input  logic                cts,
    input  logic                in_valid,
    input  logic [MAX_BITS-1:0] in_data,
    output logic                in_ready,
    output logic                tx,
    output logic                drv_en,
    output logic                tx_done
);
    line_cfg_t            cfg_now;
    logic [FRAME_MAX-1:0] frame_word;
    logic [LEN_W-1:0]     frame_len;
    logic                 accept;
    logic                 shift_en;

    assign cfg_now = '{data_bits: cfg_data_bits, par_en: cfg_parity_en,
                       par_odd: cfg_parity_odd, two_stop: cfg_two_stop};

    uart_txf_framer u_framer (
        .cfg       (cfg_now),
        .data      (in_data),
        .frame     (frame_word),
        .frame_len (frame_len)
    );

    uart_txf_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .in_valid   (in_valid),
        .cts        (cts),
        .frame_len  (frame_len),
        .accept     (accept),
        .shift_en   (shift_en),
        .busy       (drv_en),
        .done_pulse (tx_done),
        .in_ready   (in_ready)
    );

    uart_txf_shifter #(.W(FRAME_MAX)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (frame_word),
        .shift    (shift_en),
        .serial   (tx)
    );
endmodule

// File: rtl/uart_txf_chk.sv
module uart_txf_chk (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic cts,
    input logic in_ready,
    input logic tx,
    input logic drv_en,
    input logic tx_done
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> tx);

    // R6
    cts_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cts |-> !in_ready);

    // R10
    ready_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && drv_en));

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |-> !tx);

    // R10
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    // R9
    release_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_en) |-> tx_done);

    // R10
    done_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (!drv_en && $past(drv_en)));

    // R9
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_en && !bit_tick) |=> (drv_en && $stable(tx)));
endmodule

bind uart_tx_flow uart_txf_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .cts      (cts),
    .in_ready (in_ready),
    .tx       (tx),
    .drv_en   (drv_en),
    .tx_done  (tx_done)
);

// File: tb/tb_uart_tx_flow.sv
`timescale 1ns/1ps
module tb_uart_tx_flow;
    logic       clk = 1'b0;
    logic       rst;
    logic       bit_tick;
    logic [3:0] cfg_data_bits;
    logic       cfg_parity_en, cfg_parity_odd, cfg_two_stop;
    logic       cts, in_valid;
    logic [8:0] in_data;
    logic       in_ready, tx, drv_en, tx_done;

    int errors = 0;
    int checks = 0;
    int div = 4;
    int tcnt = 0;

    always #4 clk = ~clk;

    uart_tx_flow dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick),
        .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
        .cts(cts), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .tx(tx), .drv_en(drv_en), .tx_done(tx_done)
    );

    initial begin
        bit_tick = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (tcnt >= div - 1) begin tcnt = 0; bit_tick = 1'b1; end
            else begin tcnt = tcnt + 1; bit_tick = 1'b0; end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void build(input logic [8:0] d, input logic [3:0] nb_in,
                                  input logic pe, input logic po, input logic ts,
                                  output logic [12:0] b, output int len);
        int nb;
        logic p;
        nb = (nb_in < 5) ? 5 : ((nb_in > 9) ? 9 : int'(nb_in));
        b = '1;
        b[0] = 1'b0;
        p = po;
        for (int i = 0; i < nb; i++) begin
            b[1+i] = d[i];
            p = p ^ d[i];
        end
        len = 1 + nb;
        if (pe) begin b[len] = p; len = len + 1; end
        len = len + (ts ? 2 : 1);
    endfunction

    // hold: cycles with cts low and data waiting; churn: randomise cts/cfg/data mid-frame
    task automatic do_frame(input logic [8:0] d, input logic [3:0] nb, input logic pe,
                            input logic po, input logic ts, input int hold, input bit churn,
                            input string tag);
        logic [12:0] eb;
        int len, idx, guard;
        bit bits_ok, ready_ok, hold_ok;
        logic [12:0] got;
        build(d, nb, pe, po, ts, eb, len);
        @(negedge clk);
        cfg_data_bits = nb; cfg_parity_en = pe; cfg_parity_odd = po; cfg_two_stop = ts;
        in_data = d; in_valid = 1'b1;
        if (hold > 0) begin
            cts = 1'b0;
            hold_ok = 1'b1;
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                if (in_ready || drv_en || !tx) hold_ok = 1'b0;
            end
            // R6: nothing starts while cts is low
            check(hold_ok, "R6", "frame started with cts low", int'(drv_en), 0);
            cts = 1'b1;
            #1;
        end
        guard = 0;
        while (!in_ready && guard < 1000) begin @(negedge clk); guard++; end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        // R9: start bit begins the cycle after acceptance
        check(drv_en == 1'b1, "R9", {tag, " drv_en at start"}, int'(drv_en), 1);
        idx = 0; bits_ok = 1'b1; ready_ok = 1'b1; got = '1; guard = 0;
        while (drv_en && guard < 2000) begin
            if (idx < 13) got[idx] = tx;
            if (idx >= len || tx !== eb[idx]) bits_ok = 1'b0;
            if (in_ready) ready_ok = 1'b0;
            if (churn) begin
                cts = 1'($urandom);
                cfg_data_bits = 4'($urandom); cfg_parity_en = 1'($urandom);
                cfg_parity_odd = 1'($urandom); cfg_two_stop = 1'($urandom);
                in_data = 9'($urandom);
            end
            if (bit_tick) idx++;
            @(negedge clk);
            guard++;
        end
        cts = 1'b1;
        // R2 R3 R4 R7 R8: bit sequence matches the captured frame
        check(bits_ok, "R2/R3/R4/R7/R8", {tag, " frame bits"}, int'(got), int'(eb));
        // R5: frame length in bit periods
        check(idx == len, "R5", {tag, " bit periods"}, idx, len);
        // R10: ready low during frame, done pulse at release
        check(ready_ok, "R10", {tag, " in_ready during frame"}, 1, 0);
        check(tx_done == 1'b1 && tx == 1'b1, "R10", {tag, " done at release"}, int'(tx_done), 1);
        @(negedge clk);
        check(tx_done == 1'b0, "R10", {tag, " done width"}, int'(tx_done), 0);
    endtask

    initial begin
        void'($urandom(32'h1234_abcd));
        rst = 1'b1; cts = 1'b1; in_valid = 1'b0; in_data = '0;
        cfg_data_bits = 4'd8; cfg_parity_en = 1'b0; cfg_parity_odd = 1'b0; cfg_two_stop = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(tx == 1'b1 && drv_en == 1'b0 && tx_done == 1'b0, "R1", "reset outputs",
              int'({tx, drv_en, tx_done}), 4);
        check(in_ready == 1'b1, "R6", "ready after reset", int'(in_ready), 1);
        cts = 1'b0; #1;
        check(in_ready == 1'b0, "R6", "ready with cts low", int'(in_ready), 0);
        cts = 1'b1;

        do_frame(9'h0A5, 4'd8, 1'b0, 1'b0, 1'b0, 0, 1'b0, "8N1");
        do_frame(9'h0A5, 4'd8, 1'b1, 1'b0, 1'b0, 0, 1'b0, "8E1");
        do_frame(9'h0A5, 4'd8, 1'b0, 1'b0, 1'b1, 0, 1'b0, "8N2");
        do_frame(9'h1C3, 4'd9, 1'b1, 1'b1, 1'b1, 0, 1'b0, "9O2");
        do_frame(9'h1FF, 4'd5, 1'b0, 1'b0, 1'b0, 0, 1'b0, "5N1 R3 upper bits");
        do_frame(9'h1F0, 4'd2, 1'b1, 1'b0, 1'b0, 0, 1'b0, "clamp low R3");
        do_frame(9'h155, 4'd15, 1'b1, 1'b1, 1'b0, 0, 1'b0, "clamp high R3");
        div = 1;
        do_frame(9'h03C, 4'd7, 1'b1, 1'b0, 1'b1, 0, 1'b0, "tick every clock");
        div = 3;
        do_frame(9'h07E, 4'd8, 1'b0, 1'b0, 1'b0, 20, 1'b0, "cts hold R6");
        do_frame(9'h0E1, 4'd8, 1'b1, 1'b1, 1'b0, 0, 1'b1, "mid-frame churn R7 R8");

        for (int n = 0; n < 40; n++) begin
            div = 1 + int'($urandom % 5);
            do_frame(9'($urandom), 4'($urandom % 16), 1'($urandom), 1'($urandom),
                     1'($urandom), (n % 7 == 0) ? 5 : 0, 1'($urandom), "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule